// File: doc/BRIEF.md
# Two-Address Serial Register File with Clock Snapshot

This block is a byte-wide register file of 48 locations, reached over a two-wire serial bus as a slave. The master addresses the register space or a separate scratch SRAM window with two different 7-bit device addresses. Each space has its own address pointer. In a write transaction, the first data byte sets the pointer. Every later byte is stored at the pointer, and the pointer then steps forward. Read transactions return bytes from the pointer onward and step it after each byte. So a bare read continues from where the last access stopped.

Locations 00h to 06h are not stored here. Reads of them return a live time value that arrives on an input port. Writes to them are passed out on a one-cycle strobe, for the time source outside to apply, and only while a protect bit in location 08h allows it. Each read transaction into the register space first freezes the live time bytes and the alarm bytes (10h to 15h) into a holding buffer. A multi-byte read therefore returns one consistent instant, even while the time source keeps counting.

The bus lines are sampled on the system clock through two-stage synchronizers. The slave drives the data line only by pulling it low.

Top module: `i2c_regmap_slave`

## Requirements
- R1: A byte of 1101111 followed by the R/W bit (DEh write, DFh read) is acknowledged for the register space, and 1010111 (AEh/AFh) for the SRAM window. Any other device address is not acknowledged, and the slave ignores the bus until the next START.
- R2: After reset, location 07h reads 01h, 08h reads 01h, 0Bh reads 20h and 0Ch reads 46h. The other stored locations read 00h.
- R3: The first data byte of a write loads the pointer. A value above 2Fh loads 00h instead. Each later data byte is written at the pointer, and the pointer then advances.
- R4: The register pointer advances from 2Fh to 00h, on writes and on reads alike.
- R5: A write to 00h..06h is accepted only while bit 6 of location 08h is 1. An accepted write raises the time-write strobe for one clock, with the location index (0..6) and the data byte. A refused write raises no strobe. In both cases the pointer still advances.
- R6: Writes to all other register locations and to the SRAM need no enable bit.
- R7: Reads of 00h..06h return byte k of the live time input (bits 8k+7..8k) as it stood when the read's device address was acknowledged. Changes to the input during that read do not appear. Alarm locations 10h..15h are frozen the same way.
- R8: After a read, the pointer holds the address of the last byte read plus one. A read transaction that sends no pointer continues from there.
- R9: After the master answers a read byte with NACK, the slave no longer pulls the data line low for any clock pulse, until a new START.
- R10: The SRAM window has its own pointer and storage. Transactions to it neither read nor move the register pointer.
- R11: A STOP or a repeated START returns the bit-level logic to address reception, even in the middle of a byte, and keeps the pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High to pull the data line low |
| time_i | input | 56 | Live time bytes; byte k is location k |
| time_wr_o | output | 1 | One-clock strobe for an accepted time write |
| time_wr_addr_o | output | 3 | Time location index of the accepted write |
| time_wr_data_o | output | 8 | Data byte of the accepted write |

## Verification
A pointer that is off by one, or wraps at the wrong place, shows up in the very next byte returned. The bench therefore follows every write with a read that has no pointer byte, and crosses the 2Fh boundary. A snapshot taken at the wrong moment, or refreshed during a read, shows up as soon as the time input changes between two bytes of one read. Bit-level state errors show up within one clock pulse, as a missing acknowledge, or as a slave that still drives the line after NACK, STOP or a broken byte.

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave #(
  parameter int         NREG     = 48,
  parameter int         SRAM_AW  = 6,
  parameter logic [6:0] REG_DEV  = 7'h6F,
  parameter logic [6:0] SRAM_DEV = 7'h57,
  parameter int         TIME_N   = 7,
  parameter int         ALM_LO   = 16,
  parameter int         ALM_N    = 6,
  parameter int         WP_LOC   = 8,
  parameter int         WP_BIT   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [8*TIME_N-1:0]   time_i,
  output logic                  time_wr_o,
  output logic [$clog2(TIME_N)-1:0] time_wr_addr_o,
  output logic [7:0]            time_wr_data_o
);
  localparam int PW = $clog2(NREG);
  localparam int TW = $clog2(TIME_N);
  localparam int AW = $clog2(ALM_N);
  localparam int SRAM_N = 1 << SRAM_AW;
  localparam logic [7:0]    NREG8    = 8'(NREG);
  localparam logic [PW-1:0] PTOP     = PW'(NREG - 1);
  localparam logic [PW-1:0] TIME_TOP = PW'(TIME_N);
  localparam logic [PW-1:0] ALM_BASE = PW'(ALM_LO);
  localparam logic [PW-1:0] ALM_END  = PW'(ALM_LO + ALM_N);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [2:0] scl_s, sda_s;
  logic scl_r, sda_r, scl_rise, scl_fall, start_c, stop_c;
  st_t state;
  logic [3:0] cnt;
  logic [7:0] sh, rd_byte;
  logic rw, dev_sram, first, mack;
  logic [PW-1:0] ptr, ptr_inc;
  logic [SRAM_AW-1:0] sptr;
  logic [7:0] regs [NREG];
  logic [7:0] sram [SRAM_N];
  logic [TIME_N-1:0][7:0] snap_t;
  logic [ALM_N-1:0][7:0]  snap_a;
  logic [AW-1:0] aidx;
  logic reg_hit, sram_hit, byte_done, load_ptr, reg_wr, sram_wr, time_hit, rd_load, snap_take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  assign scl_r    = scl_s[1];
  assign sda_r    = sda_s[1];
  assign scl_rise = scl_s[1] & ~scl_s[2];
  assign scl_fall = ~scl_s[1] & scl_s[2];
  assign start_c  = scl_r & scl_s[2] & ~sda_s[1] & sda_s[2];
  assign stop_c   = scl_r & scl_s[2] & sda_s[1] & ~sda_s[2];

  assign reg_hit   = sh[7:1] == REG_DEV;
  assign sram_hit  = sh[7:1] == SRAM_DEV;
  assign byte_done = state == S_WR && scl_fall && cnt == 4'd8 && !start_c && !stop_c;
  assign load_ptr  = byte_done && first;
  assign reg_wr    = byte_done && !first && !dev_sram;
  assign sram_wr   = byte_done && !first && dev_sram;
  assign time_hit  = ptr < TIME_TOP;
  assign rd_load   = !start_c && !stop_c && scl_fall &&
                     ((state == S_AACK && rw) || (state == S_RACK && mack));
  assign snap_take = state == S_ADDR && scl_fall && cnt == 4'd8 && reg_hit && sh[0] &&
                     !start_c && !stop_c;
  assign ptr_inc   = (ptr == PTOP) ? '0 : ptr + 1'b1;
  assign aidx      = AW'(ptr - ALM_BASE);

  always_comb begin
    if (dev_sram)                              rd_byte = sram[sptr];
    else if (time_hit)                         rd_byte = snap_t[ptr[TW-1:0]];
    else if (ptr >= ALM_BASE && ptr < ALM_END) rd_byte = snap_a[aidx];
    else                                       rd_byte = regs[ptr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; sda_oe_o <= 1'b0;
      rw <= 1'b0; dev_sram <= 1'b0; first <= 1'b0; mack <= 1'b0;
    end else if (start_c) begin
      state <= S_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; sda_oe_o <= 1'b0;
    end else begin
      case (state)
        S_ADDR:
          if (scl_rise) begin
            sh <= {sh[6:0], sda_r};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (reg_hit || sram_hit) begin
              state <= S_AACK; sda_oe_o <= 1'b1; rw <= sh[0]; dev_sram <= sram_hit;
            end else state <= S_IDLE;
          end
        S_AACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state <= S_RD; sh <= rd_byte; sda_oe_o <= ~rd_byte[7];
            end else begin
              state <= S_WR; sda_oe_o <= 1'b0; first <= 1'b1;
            end
          end
        S_WR:
          if (scl_rise) begin
            sh <= {sh[6:0], sda_r};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            state <= S_WACK; sda_oe_o <= 1'b1; first <= 1'b0;
          end
        S_WACK:
          if (scl_fall) begin
            state <= S_WR; sda_oe_o <= 1'b0; cnt <= '0;
          end
        S_RD:
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state <= S_RACK; sda_oe_o <= 1'b0; mack <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe_o <= ~sh[6];
            end
          end
        S_RACK:
          if (scl_rise) begin
            if (sda_r) state <= S_IDLE;
            else mack <= 1'b1;
          end else if (rd_load) begin
            state <= S_RD; sh <= rd_byte; sda_oe_o <= ~rd_byte[7]; cnt <= '0;
          end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else if (load_ptr && !dev_sram) ptr <= (sh < NREG8) ? sh[PW-1:0] : '0;
    else if (reg_wr || (rd_load && !dev_sram)) ptr <= ptr_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sptr <= '0;
    else if (load_ptr && dev_sram) sptr <= sh[SRAM_AW-1:0];
    else if (sram_wr || (rd_load && dev_sram)) sptr <= sptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
      regs[7]  <= 8'h01;
      regs[8]  <= 8'h01;
      regs[11] <= 8'h20;
      regs[12] <= 8'h46;
    end else if (reg_wr && !time_hit) regs[ptr] <= sh;

  always_ff @(posedge clk)
    if (sram_wr) sram[sptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap_t <= '0;
      snap_a <= '0;
    end else if (snap_take) begin
      for (int k = 0; k < TIME_N; k++) snap_t[k] <= time_i[8*k +: 8];
      for (int k = 0; k < ALM_N; k++)  snap_a[k] <= regs[ALM_LO + k];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      time_wr_o <= 1'b0; time_wr_addr_o <= '0; time_wr_data_o <= '0;
    end else begin
      time_wr_o <= reg_wr && time_hit && regs[WP_LOC][WP_BIT];
      if (reg_wr && time_hit) begin
        time_wr_addr_o <= ptr[TW-1:0];
        time_wr_data_o <= sh;
      end
    end

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n) ptr <= PTOP);

  p_oe_states_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (state == S_AACK || state == S_WACK || state == S_RD));

  p_strobe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_o |-> (time_wr_addr_o < TW'(TIME_N)) && $past(regs[WP_LOC][WP_BIT]));

  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD || state == S_RACK) |-> $stable(snap_t) && $stable(snap_a));

  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> state == S_IDLE && !sda_oe_o);

  p_sram_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> !dev_sram);
endmodule

// File: tb/sim_i2c_regmap_slave.sv
module sim_i2c_regmap_slave;
  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_oe, twr;
  logic [2:0] twa;
  logic [7:0] twd;
  logic [55:0] time_v;
  logic sda_bus;
  int nchk = 0, nerr = 0;
  int st_cnt;
  logic [2:0] st_addr;
  logic [7:0] st_data;
  logic [7:0] exp_d[$];
  string exp_t[$];
  logic [7:0] obs;
  event obs_ev;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regmap_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .time_i(time_v), .time_wr_o(twr),
    .time_wr_addr_o(twa), .time_wr_data_o(twd));

  always @(posedge clk)
    if (!rst_n) st_cnt <= 0;
    else if (twr) begin
      st_cnt <= st_cnt + 1; st_addr <= twa; st_data <= twd;
    end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  initial forever begin
    @(obs_ev);
    if (exp_d.size() == 0) check(0, "scoreboard unexpected byte", {24'd0, obs}, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_d.pop_front();
      t = exp_t.pop_front();
      check(obs === e, t, {24'd0, obs}, {24'd0, e});
    end
  end

  task automatic hw(); repeat (8) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; hw(); scl = 1; hw(); sda_m = 0; hw(); scl = 0; hw();
  endtask

  task automatic i2c_stop();
    sda_m = 0; hw(); scl = 1; hw(); sda_m = 1; hw();
  endtask

  task automatic put_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl = 1; hw(); scl = 0;
    end
    sda_m = 1; hw(); scl = 1; hw(); ack = !sda_bus; scl = 0;
    check(ack == exp_ack, tag, {31'd0, ack}, {31'd0, exp_ack});
  endtask

  task automatic rd(input logic [7:0] e, input bit nack, input string tag);
    logic [7:0] b;
    exp_d.push_back(e);
    exp_t.push_back(tag);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1; hw(); b[i] = sda_bus; scl = 0;
    end
    sda_m = nack; hw(); scl = 1; hw(); scl = 0; hw(); sda_m = 1;
    obs = b;
    -> obs_ev;
    hw();
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    time_v = {8'h06, 8'h25, 8'h12, 8'h31, 8'h23, 8'h59, 8'h45};
    repeat (4) @(negedge clk);
    rst_n = 1;
    hw();
    check(sda_oe == 0, "R2 reset line released", {31'd0, sda_oe}, 0);
    check(twr == 0, "R2 reset no strobe", {31'd0, twr}, 0);

    // R2 reset defaults through a random read
    i2c_start(); put_byte(8'hDE, 1, "R1 reg write addr"); put_byte(8'h07, 1, "R3 ptr ack");
    i2c_start(); put_byte(8'hDF, 1, "R1 reg read addr");
    rd(8'h01, 0, "R2 loc 07h"); rd(8'h01, 0, "R2 loc 08h"); rd(8'h00, 0, "R2 loc 09h");
    rd(8'h00, 0, "R2 loc 0Ah"); rd(8'h20, 0, "R2 loc 0Bh"); rd(8'h46, 1, "R2 loc 0Ch");
    i2c_stop();

    // R1 foreign device address
    i2c_start(); put_byte(8'hA0, 0, "R1 foreign addr nack"); i2c_stop();

    // R5 refused time write, pointer still moves (R8)
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h00, 1, "R3");
    put_byte(8'h12, 1, "R5 data ack"); put_byte(8'h34, 1, "R5 data ack"); i2c_stop();
    hw();
    check(st_cnt == 0, "R5 no strobe while protected", st_cnt, 0);
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'h23, 1, "R5 ptr advanced to 02h"); i2c_stop();
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'h31, 1, "R8 current read 03h"); i2c_stop();

    // R6 control write without enable, then R5 accepted time write
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h08, 1, "R3"); put_byte(8'h41, 1, "R6"); i2c_stop();
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h05, 1, "R3"); put_byte(8'h99, 1, "R5"); i2c_stop();
    hw();
    check(st_cnt == 1, "R5 strobe count", st_cnt, 1);
    check(st_addr == 3'd5, "R5 strobe index", {29'd0, st_addr}, 5);
    check(st_data == 8'h99, "R5 strobe data", {24'd0, st_data}, 8'h99);

    // R7 snapshot holds through a multi-byte read
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h00, 1, "R3");
    i2c_start(); put_byte(8'hDF, 1, "R11 repeated start");
    rd(8'h45, 0, "R7 byte0");
    time_v = '1;
    rd(8'h59, 0, "R7 byte1 frozen"); rd(8'h23, 0, "R7 byte2 frozen"); rd(8'h31, 0, "R7 byte3 frozen");
    rd(8'h12, 0, "R7 byte4 frozen"); rd(8'h25, 0, "R7 byte5 frozen"); rd(8'h06, 1, "R7 byte6 frozen");
    i2c_stop();
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h01, 1, "R3");
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'hFF, 1, "R7 fresh snapshot"); i2c_stop();

    // R4 wrap on write and on read
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h2E, 1, "R3");
    put_byte(8'hAA, 1, "R6"); put_byte(8'hBB, 1, "R6"); put_byte(8'hCC, 1, "R4"); i2c_stop();
    hw();
    check(st_cnt == 2 && st_addr == 3'd0 && st_data == 8'hCC, "R4 write wraps to 00h",
          {st_cnt[15:0], 5'd0, st_addr, st_data}, {16'd2, 8'd0, 8'hCC});
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h2E, 1, "R3");
    i2c_start(); put_byte(8'hDF, 1, "R1");
    rd(8'hAA, 0, "R4 loc 2Eh"); rd(8'hBB, 0, "R4 loc 2Fh"); rd(8'hFF, 1, "R4 read wraps to 00h");
    i2c_stop();

    // R3 pointer byte above range loads 00h
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h40, 1, "R3"); put_byte(8'h5A, 1, "R3"); i2c_stop();
    hw();
    check(st_cnt == 3 && st_addr == 3'd0 && st_data == 8'h5A, "R3 oversized pointer",
          {st_cnt[15:0], 5'd0, st_addr, st_data}, {16'd3, 8'd0, 8'h5A});

    // R6 alarm and scratch locations
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h20, 1, "R3"); put_byte(8'h77, 1, "R6"); i2c_stop();
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h10, 1, "R3");
    for (int i = 1; i <= 6; i++) put_byte(8'(i * 3), 1, "R6 alarm write");
    i2c_stop();
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h10, 1, "R3");
    i2c_start(); put_byte(8'hDF, 1, "R1");
    for (int i = 1; i <= 6; i++) rd(8'(i * 3), i == 6, "R6 alarm read");
    i2c_stop();
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h20, 1, "R3");
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'h77, 1, "R6 scratch read"); i2c_stop();

    // R10 SRAM window keeps the register pointer
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h0B, 1, "R3"); i2c_stop();
    i2c_start(); put_byte(8'hAE, 1, "R1 sram addr");
    put_byte(8'h05, 1, "R10"); put_byte(8'h11, 1, "R10"); put_byte(8'h22, 1, "R10"); i2c_stop();
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'h20, 1, "R10 reg pointer untouched"); i2c_stop();
    i2c_start(); put_byte(8'hAE, 1, "R1"); put_byte(8'h05, 1, "R10");
    i2c_start(); put_byte(8'hAF, 1, "R1");
    rd(8'h11, 0, "R10 sram 05h"); rd(8'h22, 1, "R10 sram 06h"); i2c_stop();

    // R9 no driving after master NACK
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h0C, 1, "R3");
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'h46, 1, "R9 last byte");
    for (int i = 0; i < 9; i++) begin
      hw(); scl = 1; hw();
      check(sda_bus == 1, "R9 line released after nack", {31'd0, sda_bus}, 1);
      scl = 0;
    end
    i2c_stop();

    // R11 stop in mid byte keeps pointer
    i2c_start(); put_byte(8'hDE, 1, "R1"); put_byte(8'h0B, 1, "R3"); i2c_stop();
    i2c_start(); put_byte(8'hDE, 1, "R1");
    for (int i = 0; i < 4; i++) begin
      sda_m = 0; hw(); scl = 1; hw(); scl = 0;
    end
    i2c_stop();
    check(sda_oe == 0, "R11 released after stop", {31'd0, sda_oe}, 0);
    i2c_start(); put_byte(8'hDF, 1, "R1"); rd(8'h20, 1, "R11 pointer kept"); i2c_stop();

    hw();
    check(exp_d.size() == 0, "scoreboard drained", exp_d.size(), 0);
    finish_sim();
  end
endmodule